// File: doc/BRIEF.md
# External and Pin-Change Interrupt Controller

This controller turns activity on two dedicated external interrupt pins and on sixteen pin-change inputs into three interrupt request lines: one for each external pin and one shared by all pin-change inputs. Every input is resynchronised to the core clock. The controller then compares each pin with its previous synchronised sample and records qualifying events in sticky flags. A request is raised only when the source's flag, the source's enable bit and a global interrupt enable are all high.

Two 8-bit registers sit on a plain register bus: an enable register and a flag register. The bus has a one-bit address, a write strobe, write data and combinational read data. A single 2-bit sense setting is shared by both external pins and selects level or edge detection. The sixteen pin-change inputs fall into two enable groups that are not contiguous. Each pin also carries its own mask bit, and the mask arrives as an input port. A flag clears when its vector is acknowledged or when software writes one to its bit. There is no streaming data path, so every pin is a plain control or status signal with no valid/ready handshake.

Top module: `pin_irq_ctrl`

## Requirements
- R1: After reset both registers read 0x00 and all three request outputs are low.
- R2: The enable register is at address 0. Bit 7 enables external pin 1, bit 6 enables external pin 0, bit 5 enables pin-change group 1 and bit 4 enables pin-change group 0. Bits 3..0 always read zero, and writes to them are ignored.
- R3: The flag register is at address 1. Bit 7 is the external pin 1 flag, bit 6 is the external pin 0 flag and bit 5 is the pin-change flag. Bits 4..0 read zero. Writing a one to a flag bit clears that flag, and writing a zero leaves it unchanged.
- R4: A request output is high only while its source is active, its enable is set and `gie` is 1. The pin-change request is enabled when either group enable is set.
- R5: The sense setting applies to both external pins. Code 01 sets the flag on any change, 10 sets it on a falling edge and 11 sets it on a rising edge.
- R6: Sense code 00 selects low-level mode. In this mode the external request follows the synchronised pin, high while the pin is low and enabled with `gie` set, and the flag bit is never set.
- R7: A change on a pin-change input sets the shared pin-change flag only when both the pin's mask bit and its group enable are 1. Inputs 11..8 belong to group 0; inputs 15..12 and 7..0 belong to group 1.
- R8: A one-cycle pulse on `ack_ext0`, `ack_ext1` or `ack_pc` clears the matching flag.
- R9: When a new event and a clear (acknowledge or write-one) reach the same flag in the same cycle, the flag ends up set.
- R10: An input change shows in its flag and request on the third rising clock edge after the change: two synchroniser stages, then the flag register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 1 | Register select: 0 enable, 1 flag |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the selected register |
| gie | input | 1 | Global interrupt enable |
| sense | input | 2 | Shared external sense code |
| ext_pin | input | 2 | External interrupt pad values (bit 0 = pin 0) |
| pc_pin | input | 16 | Pin-change pad values |
| pc_mask | input | 16 | Per-pin pin-change mask |
| ack_ext0 | input | 1 | Acknowledge for external pin 0 vector |
| ack_ext1 | input | 1 | Acknowledge for external pin 1 vector |
| ack_pc | input | 1 | Acknowledge for pin-change vector |
| irq_ext0 | output | 1 | External pin 0 request |
| irq_ext1 | output | 1 | External pin 1 request |
| irq_pc | output | 1 | Shared pin-change request |

## Verification
The assertions check several rules on every cycle. An event in the previous cycle leaves its flag set, even when a clear arrives in the same cycle. A clear with no event drops the flag. Low-level mode never sets a flag. Reserved read bits are zero, and no request is high while `gie` is low. Some behaviour can only be shown by the bench scenarios, because it depends on the order of stimulus: the three-edge latency, which edges each sense code accepts, the non-contiguous group mapping combined with the masks, and the ignored writes to reserved bits.

// File: rtl/pic_pkg.sv
package pic_pkg;
  typedef enum logic [1:0] {
    SNS_LOW  = 2'b00,
    SNS_ANY  = 2'b01,
    SNS_FALL = 2'b10,
    SNS_RISE = 2'b11
  } sense_e;

  localparam int EN_EXT1_BIT = 7;
  localparam int EN_EXT0_BIT = 6;
  localparam int EN_GRP1_BIT = 5;
  localparam int EN_GRP0_BIT = 4;
  localparam int EN_LSB      = 4;

  localparam int FL_EXT1_BIT = 7;
  localparam int FL_EXT0_BIT = 6;
  localparam int FL_PC_BIT   = 5;

  localparam logic ADDR_ENABLE = 1'b0;
  localparam logic ADDR_FLAG   = 1'b1;
endpackage

// File: rtl/pic_sync.sv
module pic_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic [W-1:0] q_prev
);
  logic [W-1:0] pipe [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) pipe[0] <= '0;
          else        pipe[0] <= d;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) pipe[s] <= '0;
          else        pipe[s] <= pipe[s-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) q_prev <= '0;
    else        q_prev <= pipe[STAGES-1];

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/pic_ext_detect.sv
module pic_ext_detect
  import pic_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   lvl,
  input  logic   lvl_prev,
  input  sense_e sense,
  input  logic   clr,
  output logic   flag,
  output logic   req_src
);
  logic evt;

  always_comb begin
    unique case (sense)
      SNS_ANY:  evt = lvl ^ lvl_prev;
      SNS_FALL: evt = lvl_prev & ~lvl;
      SNS_RISE: evt = ~lvl_prev & lvl;
      default:  evt = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)   flag <= 1'b0;
    else if (evt) flag <= 1'b1;
    else if (clr) flag <= 1'b0;

  assign req_src = (sense == SNS_LOW) ? ~lvl : flag;

  a_r9_event_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && clr) |=> flag);
  a_r8_clear_drops_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !evt) |=> !flag);
  a_r6_level_never_latches: assert property (@(posedge clk) disable iff (!rst_n)
    (sense == SNS_LOW && !flag) |=> !flag);
endmodule

// File: rtl/pic_pc_detect.sv
module pic_pc_detect #(
  parameter int           W        = 16,
  parameter logic [W-1:0] GRP0_MAP = 16'h0F00
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] q,
  input  logic [W-1:0] q_prev,
  input  logic [W-1:0] mask,
  input  logic [1:0]   grp_en,
  input  logic         clr,
  output logic         flag
);
  logic [W-1:0] pin_live;
  logic         evt;

  genvar i;
  generate
    for (i = 0; i < W; i++) begin : g_pin
      if (GRP0_MAP[i]) begin : g_grp0
        assign pin_live[i] = mask[i] & grp_en[0];
      end else begin : g_grp1
        assign pin_live[i] = mask[i] & grp_en[1];
      end
    end
  endgenerate

  assign evt = |((q ^ q_prev) & pin_live);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)   flag <= 1'b0;
    else if (evt) flag <= 1'b1;
    else if (clr) flag <= 1'b0;

  a_r7_change_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> flag);
  a_r7_dead_pins_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (grp_en == 2'b00 && !flag) |=> !flag);
  a_r8_pc_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !evt) |=> !flag);
endmodule

// File: rtl/pin_irq_ctrl.sv
module pin_irq_ctrl
  import pic_pkg::*;
#(
  parameter int                  PC_WIDTH    = 16,
  parameter int                  SYNC_STAGES = 2,
  parameter logic [PC_WIDTH-1:0] PC_GRP0_MAP = 16'h0F00
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_addr,
  input  logic                reg_wr,
  input  logic [7:0]          reg_wdata,
  output logic [7:0]          reg_rdata,
  input  logic                gie,
  input  logic [1:0]          sense,
  input  logic [1:0]          ext_pin,
  input  logic [PC_WIDTH-1:0] pc_pin,
  input  logic [PC_WIDTH-1:0] pc_mask,
  input  logic                ack_ext0,
  input  logic                ack_ext1,
  input  logic                ack_pc,
  output logic                irq_ext0,
  output logic                irq_ext1,
  output logic                irq_pc
);
  localparam int EXT_N  = 2;
  localparam int EN_W   = 8 - EN_LSB;

  logic [EN_W-1:0]     en_q;
  logic                wr_en_reg, wr_flag_reg;
  logic [EXT_N-1:0]    ext_q, ext_prev, ext_flag, ext_req, ext_clr, ext_ack;
  logic [PC_WIDTH-1:0] pc_q, pc_prev;
  logic                pc_flag, pc_clr;
  logic                en_ext0, en_ext1, en_grp0, en_grp1;
  sense_e              sense_t;
  logic                unused_wdata;

  assign sense_t      = sense_e'(sense);
  assign wr_en_reg    = reg_wr && (reg_addr == ADDR_ENABLE);
  assign wr_flag_reg  = reg_wr && (reg_addr == ADDR_FLAG);
  assign unused_wdata = ^reg_wdata[EN_LSB-1:0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)         en_q <= '0;
    else if (wr_en_reg) en_q <= reg_wdata[7:EN_LSB];

  assign en_ext1 = en_q[EN_EXT1_BIT-EN_LSB];
  assign en_ext0 = en_q[EN_EXT0_BIT-EN_LSB];
  assign en_grp1 = en_q[EN_GRP1_BIT-EN_LSB];
  assign en_grp0 = en_q[EN_GRP0_BIT-EN_LSB];

  pic_sync #(.W(EXT_N), .STAGES(SYNC_STAGES)) u_ext_sync (
    .clk(clk), .rst_n(rst_n), .d(ext_pin), .q(ext_q), .q_prev(ext_prev));

  pic_sync #(.W(PC_WIDTH), .STAGES(SYNC_STAGES)) u_pc_sync (
    .clk(clk), .rst_n(rst_n), .d(pc_pin), .q(pc_q), .q_prev(pc_prev));

  assign ext_ack = {ack_ext1, ack_ext0};
  assign ext_clr[0] = ext_ack[0] | (wr_flag_reg & reg_wdata[FL_EXT0_BIT]);
  assign ext_clr[1] = ext_ack[1] | (wr_flag_reg & reg_wdata[FL_EXT1_BIT]);

  genvar e;
  generate
    for (e = 0; e < EXT_N; e++) begin : g_ext
      pic_ext_detect u_det (
        .clk(clk), .rst_n(rst_n), .lvl(ext_q[e]), .lvl_prev(ext_prev[e]),
        .sense(sense_t), .clr(ext_clr[e]), .flag(ext_flag[e]), .req_src(ext_req[e]));
    end
  endgenerate

  assign pc_clr = ack_pc | (wr_flag_reg & reg_wdata[FL_PC_BIT]);

  pic_pc_detect #(.W(PC_WIDTH), .GRP0_MAP(PC_GRP0_MAP)) u_pc_det (
    .clk(clk), .rst_n(rst_n), .q(pc_q), .q_prev(pc_prev), .mask(pc_mask),
    .grp_en({en_grp1, en_grp0}), .clr(pc_clr), .flag(pc_flag));

  always_comb begin
    reg_rdata = 8'h00;
    if (reg_addr == ADDR_ENABLE) begin
      reg_rdata[7:EN_LSB] = en_q;
    end else begin
      reg_rdata[FL_EXT1_BIT] = ext_flag[1];
      reg_rdata[FL_EXT0_BIT] = ext_flag[0];
      reg_rdata[FL_PC_BIT]   = pc_flag;
    end
  end

  assign irq_ext0 = ext_req[0] & en_ext0 & gie;
  assign irq_ext1 = ext_req[1] & en_ext1 & gie;
  assign irq_pc   = pc_flag & (en_grp1 | en_grp0) & gie;

  a_r4_gie_gates_all: assert property (@(posedge clk) disable iff (!rst_n)
    !gie |-> !(irq_ext0 || irq_ext1 || irq_pc));
  a_r2_reserved_enable_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == ADDR_ENABLE) |-> (reg_rdata[3:0] == 4'h0));
  a_r3_reserved_flag_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == ADDR_FLAG) |-> (reg_rdata[4:0] == 5'h00));
  a_r6_level_follows_pin: assert property (@(posedge clk) disable iff (!rst_n)
    (sense_t == SNS_LOW && gie && en_ext0 && !ext_q[0]) |-> irq_ext0);
endmodule

// File: tb/pin_irq_ctrl_tb.sv
`timescale 1ns/1ps
module pin_irq_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_addr, reg_wr;
  logic [7:0]  reg_wdata, reg_rdata;
  logic        gie;
  logic [1:0]  sense, ext_pin;
  logic [15:0] pc_pin, pc_mask;
  logic        ack_ext0, ack_ext1, ack_pc;
  logic        irq_ext0, irq_ext1, irq_pc;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pin_irq_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .gie(gie), .sense(sense),
    .ext_pin(ext_pin), .pc_pin(pc_pin), .pc_mask(pc_mask),
    .ack_ext0(ack_ext0), .ack_ext1(ack_ext1), .ack_pc(ack_pc),
    .irq_ext0(irq_ext0), .irq_ext1(irq_ext1), .irq_pc(irq_pc));

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic rd(input logic a, output logic [7:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic settle();
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic clear_all();
    wr(1'b1, 8'hE0);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    rd(1'b0, d); chk("R1", "enable reg after reset", d, 8'h00);
    rd(1'b1, d); chk("R1", "flag reg after reset", d, 8'h00);
    chk("R1", "requests after reset", {irq_ext1, irq_ext0, irq_pc}, 3'b000);
  endtask

  task automatic t_enable_reg();
    logic [7:0] d;
    wr(1'b0, 8'hFF);
    rd(1'b0, d); chk("R2", "reserved bits ignore writes", d, 8'hF0);
    wr(1'b0, 8'h5A);
    rd(1'b0, d); chk("R2", "enable layout 0x5A", d, 8'h50);
    wr(1'b0, 8'h00);
  endtask

  task automatic t_edges();
    logic [7:0] d;
    gie = 1'b1; wr(1'b0, 8'hC0);
    sense = 2'b10; settle();
    ext_pin[0] = 1'b1; settle();
    rd(1'b1, d); chk("R5", "falling mode ignores rise", d, 8'h00);
    ext_pin[0] = 1'b0; settle();
    rd(1'b1, d); chk("R5", "falling mode sets pin0 flag", d, 8'h40);
    chk("R4", "pin0 request with enable+gie", irq_ext0, 1'b1);
    wr(1'b1, 8'h00);
    rd(1'b1, d); chk("R3", "writing zero keeps flag", d, 8'h40);
    wr(1'b1, 8'h40);
    rd(1'b1, d); chk("R3", "write-one clears flag", d, 8'h00);
    sense = 2'b11;
    ext_pin[1] = 1'b1; settle();
    rd(1'b1, d); chk("R5", "rising mode sets pin1 flag", d, 8'h80);
    ext_pin[1] = 1'b0; clear_all(); settle();
    rd(1'b1, d); chk("R5", "rising mode ignores fall", d, 8'h00);
    sense = 2'b01;
    ext_pin[1] = 1'b1; settle();
    ext_pin[0] = 1'b1; settle();
    rd(1'b1, d); chk("R5", "any-change mode on both pins", d, 8'hC0);
    ext_pin = 2'b00; settle(); clear_all();
  endtask

  task automatic t_gie();
    logic [7:0] d;
    sense = 2'b01; wr(1'b0, 8'h40); gie = 1'b0;
    ext_pin[0] = 1'b1; settle();
    rd(1'b1, d); chk("R4", "flag sets without gie", d, 8'h40);
    chk("R4", "no request while gie low", irq_ext0, 1'b0);
    gie = 1'b1; #1;
    chk("R4", "request once gie high", irq_ext0, 1'b1);
    wr(1'b0, 8'h00);
    chk("R4", "no request with enable off", irq_ext0, 1'b0);
    ext_pin[0] = 1'b0; settle(); clear_all();
  endtask

  task automatic t_level();
    logic [7:0] d;
    sense = 2'b00; gie = 1'b1; wr(1'b0, 8'hC0);
    ext_pin = 2'b11; settle();
    chk("R6", "level high gives no request", {irq_ext1, irq_ext0}, 2'b00);
    ext_pin[1] = 1'b0; settle();
    chk("R6", "level low on pin1 requests", {irq_ext1, irq_ext0}, 2'b10);
    rd(1'b1, d); chk("R6", "level mode leaves flags clear", d, 8'h00);
    ext_pin[1] = 1'b1; settle();
    chk("R6", "request drops with level", irq_ext1, 1'b0);
    ext_pin = 2'b00; wr(1'b0, 8'h00); settle();
    sense = 2'b01; ext_pin = 2'b00; settle(); clear_all();
  endtask

  task automatic t_pc_groups();
    logic [7:0] d;
    gie = 1'b1; pc_mask = 16'hFFFF; wr(1'b0, 8'h20);
    pc_pin[9] = 1'b1; settle();
    rd(1'b1, d); chk("R7", "group0 pin ignored with only group1 on", d, 8'h00);
    pc_pin[13] = 1'b1; settle();
    rd(1'b1, d); chk("R7", "group1 pin 13 sets flag", d, 8'h20);
    chk("R4", "pin-change request", irq_pc, 1'b1);
    clear_all(); wr(1'b0, 8'h10);
    pc_pin[3] = 1'b1; settle();
    rd(1'b1, d); chk("R7", "group1 pin ignored with only group0 on", d, 8'h00);
    pc_pin[10] = 1'b1; settle();
    rd(1'b1, d); chk("R7", "group0 pin 10 sets flag", d, 8'h20);
    clear_all(); pc_mask[10] = 1'b0;
    pc_pin[10] = 1'b0; settle();
    rd(1'b1, d); chk("R7", "masked pin ignored", d, 8'h00);
    chk("R7", "masked pin no request", irq_pc, 1'b0);
    pc_mask = 16'hFFFF;
    pc_pin[8] = 1'b1; settle();
    ack_pc = 1'b1; @(negedge clk); ack_pc = 1'b0;
    rd(1'b1, d); chk("R8", "ack clears pin-change flag", d, 8'h00);
    wr(1'b0, 8'h00);
  endtask

  task automatic t_ack_and_race();
    logic [7:0] d;
    sense = 2'b01; wr(1'b0, 8'h40);
    ext_pin[0] = 1'b1; settle();
    ext_pin[0] = 1'b0;
    @(posedge clk); @(posedge clk); @(negedge clk);
    reg_addr = 1'b1; reg_wdata = 8'h40; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
    rd(1'b1, d); chk("R9", "event beats write-one clear", d, 8'h40);
    ext_pin[0] = 1'b1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    ack_ext0 = 1'b1;
    @(negedge clk); ack_ext0 = 1'b0;
    rd(1'b1, d); chk("R9", "event beats acknowledge", d, 8'h40);
    ack_ext0 = 1'b1; @(negedge clk); ack_ext0 = 1'b0;
    rd(1'b1, d); chk("R8", "ack clears pin0 flag", d, 8'h00);
    wr(1'b0, 8'h80); ext_pin[1] = 1'b1; settle();
    ack_ext1 = 1'b1; @(negedge clk); ack_ext1 = 1'b0;
    rd(1'b1, d); chk("R8", "ack clears pin1 flag", d, 8'h00);
    chk("R8", "pin1 request gone", irq_ext1, 1'b0);
    ext_pin = 2'b00; settle(); clear_all();
  endtask

  task automatic t_latency();
    logic [7:0] d;
    sense = 2'b11; gie = 1'b1; wr(1'b0, 8'h80);
    ext_pin[1] = 1'b1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    rd(1'b1, d); chk("R10", "flag still clear after two edges", d, 8'h00);
    chk("R10", "request still low after two edges", irq_ext1, 1'b0);
    @(posedge clk); @(negedge clk);
    rd(1'b1, d); chk("R10", "flag set on third edge", d, 8'h80);
    chk("R10", "request on third edge", irq_ext1, 1'b1);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    rst_n = 1'b0; reg_addr = 1'b0; reg_wr = 1'b0; reg_wdata = 8'h00;
    gie = 1'b0; sense = 2'b00; ext_pin = 2'b00; pc_pin = 16'h0000;
    pc_mask = 16'h0000; ack_ext0 = 1'b0; ack_ext1 = 1'b0; ack_pc = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    t_reset();
    t_enable_reg();
    t_edges();
    t_gie();
    t_level();
    t_pc_groups();
    t_ack_and_race();
    t_latency();
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end
endmodule